// File: doc/BRIEF.md
# Three-Port Latched Bus Exchanger

This block connects one host-side data port (A) to two memory-side data ports (B1 and B2). Every transfer direction owns a storage stage of its own. Two stages carry data from A towards B1 and towards B2. Two more stages carry data from B1 and from B2 back towards A. A route select picks which of the two return stages drives A. This lets a host interleave reads from two memory banks, or fan a multiplexed address out to both banks and keep it there.

Each bidirectional pin is split into three parts: an incoming value with a valid flag, an outgoing value, and an active-high drive flag. Each port's drive flag follows an active-low drive request. While a port's valid flag is low, the port is treated as floating. That port then presents the last value it saw while valid, so a floating pin never feeds unknown data into a stage.

Each stage is a register clocked by the system clock, not a true level latch. While its enable is high, it loads its source every cycle, so its output follows its source one cycle later. At the first clock edge where its enable is low, it keeps the last value loaded and holds it until the enable rises again.

Top module: `bus_xchg3`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four stages and all three hold values are cleared to zero. While `rst_n` is low, all three drive flags (`a_pin_oe`, `b1_pin_oe`, `b2_pin_oe`) are 0.
- R2: At each edge where `le_a_b1` is 1, the A-to-B1 stage loads the value port A presents. `b1_pin_out` shows that value after the edge.
- R3: At each edge where a stage's enable is 0, the stage keeps its content. The stage therefore holds the value loaded at the last edge where its enable was 1.
- R4: The A-to-B2 stage, enabled by `le_a_b2`, loads port A's value in the same way. It is independent of the A-to-B1 stage, and both may load at the same edge.
- R5: The B1-to-A stage (`le_b1_a`) loads port B1's value, and the B2-to-A stage (`le_b2_a`) loads port B2's value. `a_pin_out` shows the B1-to-A stage when `pick_b1` is 1 and the B2-to-A stage when `pick_b1` is 0. The select acts in the same cycle.
- R6: Out of reset, each port's drive flag is 1 exactly when its active-low request (`a_drive_n`, `b1_drive_n`, `b2_drive_n`) is 0. The drive flag acts in the same cycle.
- R7: The two B-port drive requests are independent. Any combination of them gives the matching pair of drive flags, so one B port can drive while the other receives.
- R8: While a port's valid flag is 0, the value that port presents to the stages is the last value seen at an edge where its valid flag was 1. If no such edge has occurred since reset, the value is 0.
- R9: Changing `pick_b1` does not alter the content of either return stage. Switching the select back shows the earlier value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_pin_in | input | W | Value on port A pins |
| a_pin_vld | input | 1 | Port A pins driven externally (0 = floating) |
| a_pin_out | output | W | Value port A drives |
| a_pin_oe | output | 1 | Port A drive flag |
| b1_pin_in | input | W | Value on port B1 pins |
| b1_pin_vld | input | 1 | Port B1 pins driven externally |
| b1_pin_out | output | W | Value port B1 drives |
| b1_pin_oe | output | 1 | Port B1 drive flag |
| b2_pin_in | input | W | Value on port B2 pins |
| b2_pin_vld | input | 1 | Port B2 pins driven externally |
| b2_pin_out | output | W | Value port B2 drives |
| b2_pin_oe | output | 1 | Port B2 drive flag |
| le_a_b1 | input | 1 | Enable of the A-to-B1 stage |
| le_a_b2 | input | 1 | Enable of the A-to-B2 stage |
| le_b1_a | input | 1 | Enable of the B1-to-A stage |
| le_b2_a | input | 1 | Enable of the B2-to-A stage |
| pick_b1 | input | 1 | Route select: 1 = B1 stage drives A, 0 = B2 stage |
| a_drive_n | input | 1 | Active-low drive request for port A |
| b1_drive_n | input | 1 | Active-low drive request for port B1 |
| b2_drive_n | input | 1 | Active-low drive request for port B2 |

## Verification
A stage can load at the same edge where its source port starts to float. In that case, the stage must take the held value and not the garbage left on the pins. The bench provokes this by dropping `a_pin_vld` while `le_a_b1` stays high and driving an all-ones pattern on the pins. A reference model in the bench computes the port's presented value from its own hold copy. That result is compared with `b1_pin_out` after the edge. Select switching while both return stages are frozen is judged in the same way, by flipping `pick_b1` back and forth and expecting the earlier values to reappear.

// File: rtl/xchg_pkg.sv
// Package: shared constants for the three-port exchanger.
// Assumes port order A=0, B1=1, B2=2 and stage order A->B1, A->B2,
// B1->A, B2->A throughout the design.
package xchg_pkg;
    localparam int NPORT = 3;
    localparam int NPATH = 4;

    localparam int PORT_A  = 0;
    localparam int PORT_B1 = 1;
    localparam int PORT_B2 = 2;

    localparam int PATH_A_B1 = 0;
    localparam int PATH_A_B2 = 1;
    localparam int PATH_B1_A = 2;
    localparam int PATH_B2_A = 3;

    // Source port feeding a given stage.
    function automatic int path_src(input int path);
        case (path)
            PATH_A_B1, PATH_A_B2: return PORT_A;
            PATH_B1_A:            return PORT_B1;
            default:              return PORT_B2;
        endcase
    endfunction
endpackage

// File: rtl/xchg_bus_hold.sv
// Module: per-port keeper. Presents the pin value while the pin is
// driven from outside, and the last such value while it floats.
// Assumes synchronous active-low reset clears the kept value to zero.
module xchg_bus_hold #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic         pin_vld,
    output logic [W-1:0] seen
);
    logic [W-1:0] kept_q;

    // Remember the last externally driven value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kept_q <= '0;
        end else if (pin_vld) begin
            kept_q <= pin_in;
        end
    end

    // Value the stages see this cycle.
    always_comb begin
        seen = pin_vld ? pin_in : kept_q;
    end
endmodule

// File: rtl/xchg_path_latch.sv
// Module: one direction stage. Loads its source at every edge with the
// enable high and keeps its content at every edge with the enable low.
// Assumes enable and data are synchronous to clk.
module xchg_path_latch #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Sampling register standing in for a transparent latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (open_en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/bus_xchg3.sv
// Module: three-port latched bus exchanger (top). Port A talks to ports
// B1 and B2 through four independently enabled direction stages; a route
// select picks which return stage drives A. Pins are split into
// in/valid/out/drive-flag. Assumes one clock domain, synchronous reset.
module bus_xchg3 #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_pin_in,
    input  logic         a_pin_vld,
    output logic [W-1:0] a_pin_out,
    output logic         a_pin_oe,
    input  logic [W-1:0] b1_pin_in,
    input  logic         b1_pin_vld,
    output logic [W-1:0] b1_pin_out,
    output logic         b1_pin_oe,
    input  logic [W-1:0] b2_pin_in,
    input  logic         b2_pin_vld,
    output logic [W-1:0] b2_pin_out,
    output logic         b2_pin_oe,
    input  logic         le_a_b1,
    input  logic         le_a_b2,
    input  logic         le_b1_a,
    input  logic         le_b2_a,
    input  logic         pick_b1,
    input  logic         a_drive_n,
    input  logic         b1_drive_n,
    input  logic         b2_drive_n
);
    import xchg_pkg::*;

    logic [NPORT-1:0][W-1:0] pin_in;
    logic [NPORT-1:0]        pin_vld;
    logic [NPORT-1:0][W-1:0] seen;
    logic [NPORT-1:0]        drive_n;
    logic [NPORT-1:0]        drive;
    logic [NPATH-1:0]        le;
    logic [NPATH-1:0][W-1:0] held;

    // Gather per-port and per-stage inputs into indexed vectors.
    always_comb begin
        pin_in[PORT_A]   = a_pin_in;
        pin_in[PORT_B1]  = b1_pin_in;
        pin_in[PORT_B2]  = b2_pin_in;
        pin_vld[PORT_A]  = a_pin_vld;
        pin_vld[PORT_B1] = b1_pin_vld;
        pin_vld[PORT_B2] = b2_pin_vld;
        drive_n[PORT_A]  = a_drive_n;
        drive_n[PORT_B1] = b1_drive_n;
        drive_n[PORT_B2] = b2_drive_n;
        le[PATH_A_B1]    = le_a_b1;
        le[PATH_A_B2]    = le_a_b2;
        le[PATH_B1_A]    = le_b1_a;
        le[PATH_B2_A]    = le_b2_a;
    end

    // One keeper and one drive gate per port.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        xchg_bus_hold #(.W(W)) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_in  (pin_in[p]),
            .pin_vld (pin_vld[p]),
            .seen    (seen[p])
        );
        assign drive[p] = rst_n & ~drive_n[p];
    end

    // One stage per direction, fed from its source port.
    for (genvar s = 0; s < NPATH; s++) begin : g_path
        xchg_path_latch #(.W(W)) u_lat (
            .clk     (clk),
            .rst_n   (rst_n),
            .open_en (le[s]),
            .d       (seen[path_src(s)]),
            .q       (held[s])
        );
    end

    // Route select and output mapping.
    always_comb begin
        a_pin_out  = pick_b1 ? held[PATH_B1_A] : held[PATH_B2_A];
        b1_pin_out = held[PATH_A_B1];
        b2_pin_out = held[PATH_A_B2];
        a_pin_oe   = drive[PORT_A];
        b1_pin_oe  = drive[PORT_B1];
        b2_pin_oe  = drive[PORT_B2];
    end
endmodule

// File: rtl/bus_xchg3_chk.sv
// Module: assertion checker for bus_xchg3, attached by bind.
// Assumes it observes the top's ports and port A's presented value.
module bus_xchg3_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         le_a_b1,
    input logic         le_a_b2,
    input logic         le_b1_a,
    input logic         le_b2_a,
    input logic         pick_b1,
    input logic         a_pin_vld,
    input logic         b1_drive_n,
    input logic         b2_drive_n,
    input logic [W-1:0] a_pin_out,
    input logic [W-1:0] b1_pin_out,
    input logic [W-1:0] b2_pin_out,
    input logic         a_pin_oe,
    input logic         b1_pin_oe,
    input logic         b2_pin_oe,
    input logic [W-1:0] seen_a
);
    // R1: no port drives while in reset.
    always_comb begin
        if (!rst_n) begin
            a_r1_no_drive_in_reset: assert (!a_pin_oe && !b1_pin_oe && !b2_pin_oe);
        end
    end

    a_r1_cleared_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (a_pin_out == '0 && b1_pin_out == '0 && b2_pin_out == '0));

    a_r2_b1_follows_a: assert property (@(posedge clk) disable iff (!rst_n)
        le_a_b1 |=> (b1_pin_out == $past(seen_a)));

    a_r3_b1_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !le_a_b1 |=> $stable(b1_pin_out));

    a_r4_b2_follows_a: assert property (@(posedge clk) disable iff (!rst_n)
        le_a_b2 |=> (b2_pin_out == $past(seen_a)));

    a_r9_frozen_route: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_b1_a && !le_b2_a) ##1 $stable(pick_b1) |-> $stable(a_pin_out));

    a_r7_b2_flag_indep: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(b2_drive_n) |-> $stable(b2_pin_oe));

    a_r7_b1_flag_indep: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(b1_drive_n) |-> $stable(b1_pin_oe));

    a_r8_float_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !a_pin_vld ##1 !a_pin_vld |-> $stable(seen_a));
endmodule

bind bus_xchg3 bus_xchg3_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .le_a_b1    (le_a_b1),
    .le_a_b2    (le_a_b2),
    .le_b1_a    (le_b1_a),
    .le_b2_a    (le_b2_a),
    .pick_b1    (pick_b1),
    .a_pin_vld  (a_pin_vld),
    .b1_drive_n (b1_drive_n),
    .b2_drive_n (b2_drive_n),
    .a_pin_out  (a_pin_out),
    .b1_pin_out (b1_pin_out),
    .b2_pin_out (b2_pin_out),
    .a_pin_oe   (a_pin_oe),
    .b1_pin_oe  (b1_pin_oe),
    .b2_pin_oe  (b2_pin_oe),
    .seen_a     (seen[0])
);

// File: tb/tb_bus_xchg3.sv
// Bench: scoreboard for bus_xchg3. The driver applies one cycle of stimulus
// at the falling edge, advances a reference model and queues the expected
// outputs; the monitor compares them shortly after the next rising edge.
module tb_bus_xchg3;
    localparam int W          = 12;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int EW         = 3 * W + 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic         a_vld = 1'b0, b1_vld = 1'b0, b2_vld = 1'b0;
    logic         le0 = 1'b0, le1 = 1'b0, le2 = 1'b0, le3 = 1'b0;
    logic         sel = 1'b0;
    logic         dna = 1'b1, dn1 = 1'b1, dn2 = 1'b1;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_oe, b1_oe, b2_oe;

    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;

    logic [EW-1:0] exp_q[$];
    string         tag_q[$];

    // Reference model state.
    logic [W-1:0] m_hold [3];
    logic [W-1:0] m_lat  [4];

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_xchg3 #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_pin_in(a_in), .a_pin_vld(a_vld), .a_pin_out(a_out), .a_pin_oe(a_oe),
        .b1_pin_in(b1_in), .b1_pin_vld(b1_vld), .b1_pin_out(b1_out), .b1_pin_oe(b1_oe),
        .b2_pin_in(b2_in), .b2_pin_vld(b2_vld), .b2_pin_out(b2_out), .b2_pin_oe(b2_oe),
        .le_a_b1(le0), .le_a_b2(le1), .le_b1_a(le2), .le_b2_a(le3),
        .pick_b1(sel), .a_drive_n(dna), .b1_drive_n(dn1), .b2_drive_n(dn2)
    );

    // Driver: one cycle of stimulus plus expected outputs after the next edge.
    // v and dn bits: 0 = A, 1 = B1, 2 = B2; le bits: 0 A->B1, 1 A->B2, 2 B1->A, 3 B2->A.
    task automatic step(input logic r, input logic [W-1:0] a, input logic [W-1:0] b1,
                        input logic [W-1:0] b2, input logic [2:0] v, input logic [3:0] le,
                        input logic s, input logic [2:0] dn, input string tag);
        logic [W-1:0] eff [3];
        logic [W-1:0] ea;
        @(negedge clk);
        rst_n = r; a_in = a; b1_in = b1; b2_in = b2;
        a_vld = v[0]; b1_vld = v[1]; b2_vld = v[2];
        le0 = le[0]; le1 = le[1]; le2 = le[2]; le3 = le[3];
        sel = s; dna = dn[0]; dn1 = dn[1]; dn2 = dn[2];
        eff[0] = v[0] ? a  : m_hold[0];
        eff[1] = v[1] ? b1 : m_hold[1];
        eff[2] = v[2] ? b2 : m_hold[2];
        if (!r) begin
            for (int i = 0; i < 3; i++) m_hold[i] = '0;
            for (int i = 0; i < 4; i++) m_lat[i] = '0;
        end else begin
            if (v[0]) m_hold[0] = a;
            if (v[1]) m_hold[1] = b1;
            if (v[2]) m_hold[2] = b2;
            if (le[0]) m_lat[0] = eff[0];
            if (le[1]) m_lat[1] = eff[0];
            if (le[2]) m_lat[2] = eff[1];
            if (le[3]) m_lat[3] = eff[2];
        end
        ea = s ? m_lat[2] : m_lat[3];
        exp_q.push_back({ea, m_lat[0], m_lat[1], r & ~dn[0], r & ~dn[1], r & ~dn[2]});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare outputs against the queued expectation.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [EW-1:0] e, act;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            act = {a_out, b1_out, b2_out, a_oe, b1_oe, b2_oe};
            checks++;
            if (act !== e) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", t, act, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) m_hold[i] = '0;
        for (int i = 0; i < 4; i++) m_lat[i] = '0;
        // R1: reset with inputs active, flags must stay off.
        step(0, 12'h5A5, 12'h3C3, 12'h0F0, 3'b111, 4'b1111, 1, 3'b000, "R1 reset");
        step(0, 12'h5A5, 12'h3C3, 12'h0F0, 3'b111, 4'b1111, 0, 3'b000, "R1 reset");
        step(1, 12'h000, 12'h000, 12'h000, 3'b111, 4'b0000, 0, 3'b111, "R1 after reset");
        // R2: A->B1 transparent.
        step(1, 12'h123, 0, 0, 3'b111, 4'b0001, 0, 3'b111, "R2 follow");
        step(1, 12'h456, 0, 0, 3'b111, 4'b0001, 0, 3'b111, "R2 follow");
        // R3: capture on falling enable and hold.
        step(1, 12'h789, 0, 0, 3'b111, 4'b0000, 0, 3'b111, "R3 capture");
        step(1, 12'hABC, 0, 0, 3'b111, 4'b0000, 0, 3'b111, "R3 hold");
        // R4: A->B2 alone, then both together.
        step(1, 12'h321, 0, 0, 3'b111, 4'b0010, 0, 3'b111, "R4 b2 only");
        step(1, 12'h654, 0, 0, 3'b111, 4'b0011, 0, 3'b111, "R4 both");
        step(1, 12'h987, 0, 0, 3'b111, 4'b0000, 0, 3'b111, "R4 both held");
        // R5: return stages and select.
        step(1, 0, 12'hB11, 12'hB22, 3'b111, 4'b1100, 1, 3'b111, "R5 load pick b1");
        step(1, 0, 12'h111, 12'h222, 3'b111, 4'b0000, 0, 3'b111, "R5 pick b2");
        // R9: select flips do not disturb contents.
        step(1, 0, 12'h333, 12'h444, 3'b111, 4'b0000, 1, 3'b111, "R9 back to b1");
        step(1, 0, 12'h333, 12'h444, 3'b111, 4'b0000, 0, 3'b111, "R9 back to b2");
        // R6, R7: drive flags in every combination.
        for (int k = 0; k < 8; k++) begin
            step(1, 0, 0, 0, 3'b111, 4'b0000, 1, 3'(k), "R6 R7 drive flags");
        end
        // R3 on return stage: B1->A holds while B1 pins change.
        step(1, 0, 12'hC0C, 0, 3'b111, 4'b0100, 1, 3'b010, "R3 b1 stage load");
        step(1, 0, 12'hD0D, 0, 3'b111, 4'b0000, 1, 3'b010, "R3 b1 stage hold");
        // R8: A floats while A->B1 stays open; garbage on pins is ignored.
        step(1, 12'h0F0, 0, 0, 3'b111, 4'b0001, 0, 3'b101, "R8 valid load");
        step(1, 12'hFFF, 0, 0, 3'b110, 4'b0001, 0, 3'b101, "R8 float same edge");
        step(1, 12'hAAA, 0, 0, 3'b110, 4'b0011, 0, 3'b101, "R8 float keeps");
        // R8: B2 floats into return stage.
        step(1, 0, 0, 12'h5E5, 3'b111, 4'b1000, 0, 3'b111, "R8 b2 valid");
        step(1, 0, 0, 12'h000, 3'b011, 4'b1000, 0, 3'b111, "R8 b2 float");
        // R1: reset in mid-run clears everything.
        step(0, 12'h777, 12'h777, 12'h777, 3'b111, 4'b1111, 1, 3'b000, "R1 mid reset");
        step(1, 12'h000, 0, 0, 3'b000, 4'b1111, 1, 3'b111, "R8 floats after reset give zero");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule